// File: doc/BRIEF.md
# Pseudo-SRAM Power-Up and Refresh Guard

This block sits between a host that drives a plain asynchronous-SRAM style control bus and a single-transistor-cell pseudo-SRAM that refreshes itself internally. The memory can only refresh while it is not selected, or while it sees real read cycles. This guard provides those windows. After reset it keeps chip-select inactive for a start-up interval. It then issues a set number of dummy reads and only after that lets the host through.

During normal operation the host's select, write, output-enable, byte-lane and address lines pass straight to the memory pins. A monitor counts the cycles in which the memory is selected without a refresh opportunity. Such a cycle is a write, or a read that repeats the address of the previous selected cycle. When that count reaches its limit, the guard pulls the host's ready low and forces chip-select inactive for a gap. It then hands the held access back to the pins unchanged. A sleep request drives the deep power-down pin, in which state the memory contents are lost. Leaving that state runs either a wait followed by dummy reads, or one longer select-inactive hold. A parameter chooses which. All intervals are counted in clock cycles. The data bus is wired directly between host and memory and does not pass through the block.

Top module: `psram_refresh_guard`

## Requirements
- R1: After reset, `mem_cs_n` and `mem_zz_n` stay high and `host_ready` stays low for exactly PWRUP_CYC cycles.
- R2: After that wait the guard issues DUMMY_RD dummy reads. Each lasts RD_CYC cycles with `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1, both byte-lane enables low and `mem_addr`=0. Each read is followed by one cycle with `mem_cs_n` high. `host_ready` is low throughout and rises in the cycle after the last of those high cycles.
- R3: While `host_ready` is high, the memory pins follow the host in the same cycle: `mem_cs_n`=!host_sel, `mem_we_n`=!(host_sel&host_wr), `mem_oe_n`=!(host_sel&!host_wr), `mem_addr`=host_addr, and byte lanes equal `host_be_n` when selected and high otherwise.
- R4: A starving cycle is a selected ready cycle that is a write, or a read whose address equals that of the previous cycle while chip-select was already low. After STARVE_CYC starving cycles in a row, `host_ready` goes low and `mem_cs_n` goes high for exactly GAP_CYC cycles. A held same-address read is therefore passed for STARVE_CYC+1 cycles.
- R5: Back-to-back writes count as starving even when the address changes every cycle, so a write burst starting from idle is stalled after STARVE_CYC accepted writes.
- R6: Reads that change address every cycle never cause a stall.
- R7: A ready cycle with `host_sel` low restarts the starvation interval.
- R8: When `host_sleep` is high in a ready cycle, `mem_zz_n` goes low from the next cycle on. `mem_cs_n` and `mem_we_n` stay high and `host_ready` stays low whatever the host drives, until `host_sleep` falls.
- R9: With WAKE_HOLD=0, after `host_sleep` falls the guard holds `mem_cs_n` high with `mem_zz_n` high for WAKE_CYC cycles. It then repeats the dummy-read sequence of R2.
- R10: With WAKE_HOLD=1, after `host_sleep` falls the guard holds `mem_cs_n` high for HOLD_CYC cycles and then raises `host_ready` without any dummy reads.
- R11: When a forced gap ends, the access the host held during the stall appears on the pins with the same address and direction.
- R12: `host_sleep` has no effect before `host_ready` first rises. `mem_zz_n` stays high through the power-up wait and dummy reads.
- R13: While `host_ready` is low and `mem_zz_n` is high, `mem_we_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host requests an access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host word address |
| host_be_n | input | 2 | Active-low byte-lane enables, bit 0 lower lane |
| host_sleep | input | 1 | Request for deep power-down |
| host_ready | output | 1 | Access accepted this cycle; low = stalled |
| mem_cs_n | output | 1 | Memory chip-select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Memory lower byte enable, active low |
| mem_ub_n | output | 1 | Memory upper byte enable, active low |
| mem_zz_n | output | 1 | Deep power-down pin, low = power-down |
| mem_addr | output | AW | Memory address |

## Verification
The forced gap only appears after an unbroken run of starving cycles. Random traffic rarely builds one long enough, and any fresh-address read or idle cycle restarts the count. The stimulus therefore combines directed held reads, same-address and address-walking write bursts, and a burst split by a single idle cycle with a long random stream. That stream is biased toward writes and repeated-address reads, so gaps occur many times at varied points. The bench models the starvation count from the pins, checks every gap length, and confirms that the stalled access resumes unchanged. The sleep-then-wake paths are driven for both wake variants, with a second instance held in sleep from reset.

// File: rtl/psg_pkg.sv
// Shared types of the pseudo-SRAM refresh guard.
package psg_pkg;
    // Sequencer states: start-up/wake wait, dummy read, separator, pass-through,
    // forced gap, deep power-down.
    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,
        ST_DRD  = 3'd1,
        ST_DSEP = 3'd2,
        ST_RUN  = 3'd3,
        ST_GAP  = 3'd4,
        ST_DPD  = 3'd5
    } psg_state_e;
endpackage

// File: rtl/psg_timer.sv
// Loadable down-counter. Reports done while the count is zero.
// Assumes: load has priority over counting; the count holds at zero.
module psg_timer #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Count down toward zero, or reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RST_VAL;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/psg_starve_mon.sv
// Counts selected cycles that give the memory no refresh opportunity.
// A write, or a read that repeats the previous address while chip-select was
// already low, is starving. An idle cycle or a read that opens a new address
// or a new select restarts the count. Raises hit in the starving cycle that
// completes STARVE_CYC in a row.
// Assumes: run is high only while host traffic passes to the pins.
module psg_starve_mon #(
    parameter int AW         = 21,
    parameter int STARVE_CYC = 400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic          cs_active,
    output logic          hit
);
    localparam int CW = $clog2(STARVE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STARVE_CYC - 1);

    logic          last_cs_q;
    logic [AW-1:0] last_addr_q;
    logic [CW-1:0] cnt_q;
    logic          fresh_rd;
    logic          refresh_ok;

    // A read is genuine when the select or the address is new.
    assign fresh_rd   = sel && !wr && (!last_cs_q || (addr != last_addr_q));
    assign refresh_ok = !sel || fresh_rd;
    assign hit        = run && !refresh_ok && (cnt_q == LIMIT);

    // Track the previous pin cycle and the run of starving cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cs_q   <= 1'b0;
            last_addr_q <= '0;
            cnt_q       <= '0;
        end else begin
            last_cs_q   <= cs_active;
            last_addr_q <= addr;
            if (!run || refresh_ok || hit)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/psg_seq.sv
// Sequencer of the refresh guard: start-up wait, dummy reads, pass-through,
// forced chip-select gaps, deep power-down and the wake path.
// Assumes: DUMMY_RD >= 1 and every interval parameter >= 1.
module psg_seq
    import psg_pkg::*;
#(
    parameter int PWRUP_CYC = 20000,
    parameter int WAKE_CYC  = 20000,
    parameter int HOLD_CYC  = 30000,
    parameter int WAKE_HOLD = 0,
    parameter int RD_CYC    = 10,
    parameter int GAP_CYC   = 10,
    parameter int DUMMY_RD  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    input  logic       hit,
    output psg_state_e state
);
    localparam int M0   = (PWRUP_CYC > WAKE_CYC) ? PWRUP_CYC : WAKE_CYC;
    localparam int M1   = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam int M2   = (M0 > M1) ? M0 : M1;
    localparam int MAXV = (M2 > RD_CYC) ? M2 : RD_CYC;
    localparam int TW   = $clog2(MAXV + 1);
    localparam int RW   = $clog2(DUMMY_RD + 1);

    localparam logic [TW-1:0] PWR_LD  = TW'(PWRUP_CYC - 1);
    localparam logic [TW-1:0] RD_LD   = TW'(RD_CYC - 1);
    localparam logic [TW-1:0] GAP_LD  = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] WAKE_LD = (WAKE_HOLD != 0) ? TW'(HOLD_CYC - 1) : TW'(WAKE_CYC - 1);
    localparam logic [RW-1:0] NRD     = RW'(DUMMY_RD);

    psg_state_e    st_q, st_d;
    logic          then_rd_q, then_rd_d;
    logic [RW-1:0] left_q, left_d;
    logic          ld;
    logic [TW-1:0] ld_val;
    logic          done;

    psg_timer #(.W(TW), .RST_VAL(PWR_LD)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (done)
    );

    // Next state, timer reloads and dummy-read bookkeeping.
    always_comb begin
        st_d      = st_q;
        then_rd_d = then_rd_q;
        left_d    = left_q;
        ld        = 1'b0;
        ld_val    = RD_LD;
        case (st_q)
            ST_WAIT: begin
                if (done) begin
                    if (then_rd_q) begin
                        st_d   = ST_DRD;
                        ld     = 1'b1;
                        ld_val = RD_LD;
                        left_d = NRD;
                    end else begin
                        st_d = ST_RUN;
                    end
                end
            end
            ST_DRD: begin
                if (done)
                    st_d = ST_DSEP;
            end
            ST_DSEP: begin
                if (left_q <= RW'(1)) begin
                    st_d = ST_RUN;
                end else begin
                    left_d = left_q - 1'b1;
                    st_d   = ST_DRD;
                    ld     = 1'b1;
                    ld_val = RD_LD;
                end
            end
            ST_RUN: begin
                if (sleep) begin
                    st_d = ST_DPD;
                end else if (hit) begin
                    st_d   = ST_GAP;
                    ld     = 1'b1;
                    ld_val = GAP_LD;
                end
            end
            ST_GAP: begin
                if (done)
                    st_d = ST_RUN;
            end
            ST_DPD: begin
                if (!sleep) begin
                    st_d      = ST_WAIT;
                    ld        = 1'b1;
                    ld_val    = WAKE_LD;
                    then_rd_d = (WAKE_HOLD == 0);
                end
            end
            default: st_d = ST_WAIT;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_WAIT;
            then_rd_q <= 1'b1;
            left_q    <= NRD;
        end else begin
            st_q      <= st_d;
            then_rd_q <= then_rd_d;
            left_q    <= left_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/psram_refresh_guard.sv
// Guard between an SRAM-style host bus and a self-refreshing pseudo-SRAM.
// It runs the start-up and wake sequences, passes host accesses through,
// and forces chip-select gaps when the host starves the internal refresh.
// Assumes: the host holds its request unchanged while host_ready is low;
// the data bus connects host and memory directly.
module psram_refresh_guard
    import psg_pkg::*;
#(
    parameter int AW         = 21,
    parameter int PWRUP_CYC  = 20000,
    parameter int WAKE_CYC   = 20000,
    parameter int HOLD_CYC   = 30000,
    parameter int WAKE_HOLD  = 0,
    parameter int RD_CYC     = 10,
    parameter int GAP_CYC    = 10,
    parameter int STARVE_CYC = 400,
    parameter int DUMMY_RD   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [1:0]    host_be_n,
    input  logic          host_sleep,
    output logic          host_ready,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic          mem_zz_n,
    output logic [AW-1:0] mem_addr
);
    psg_state_e state;
    logic       hit;
    logic       run;

    assign run = (state == ST_RUN);

    psg_seq #(
        .PWRUP_CYC (PWRUP_CYC),
        .WAKE_CYC  (WAKE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .WAKE_HOLD (WAKE_HOLD),
        .RD_CYC    (RD_CYC),
        .GAP_CYC   (GAP_CYC),
        .DUMMY_RD  (DUMMY_RD)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .sleep (host_sleep),
        .hit   (hit),
        .state (state)
    );

    psg_starve_mon #(.AW(AW), .STARVE_CYC(STARVE_CYC)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sel       (host_sel),
        .wr        (host_wr),
        .addr      (host_addr),
        .cs_active (!mem_cs_n),
        .hit       (hit)
    );

    // Drive the memory pins from the host or from the sequencer.
    always_comb begin
        mem_cs_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_lb_n   = 1'b1;
        mem_ub_n   = 1'b1;
        mem_addr   = '0;
        mem_zz_n   = (state != ST_DPD);
        host_ready = run;
        case (state)
            ST_RUN: begin
                mem_cs_n = !host_sel;
                mem_we_n = !(host_sel && host_wr);
                mem_oe_n = !(host_sel && !host_wr);
                mem_lb_n = host_sel ? host_be_n[0] : 1'b1;
                mem_ub_n = host_sel ? host_be_n[1] : 1'b1;
                mem_addr = host_addr;
            end
            ST_DRD: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_lb_n = 1'b0;
                mem_ub_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/psram_refresh_guard_chk.sv
// Property checker for the refresh guard, attached by bind.
// Assumes: observes only the ports of the guard.
module psram_refresh_guard_chk #(
    parameter int AW         = 21,
    parameter int STARVE_CYC = 400
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_sel,
    input logic          host_ready,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_lb_n,
    input logic          mem_ub_n,
    input logic          mem_zz_n,
    input logic [AW-1:0] mem_addr
);
    localparam int SCW = $clog2(STARVE_CYC + 1) + 1;

    logic           p_csn_q;
    logic [AW-1:0]  p_addr_q;
    logic [SCW-1:0] sc_q;
    logic           fresh;
    logic           starving;

    assign fresh    = !mem_oe_n && (p_csn_q || (mem_addr != p_addr_q));
    assign starving = host_ready && !mem_cs_n && !fresh;

    // Independent count of starving pin cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_csn_q  <= 1'b1;
            p_addr_q <= '0;
            sc_q     <= '0;
        end else begin
            p_csn_q  <= mem_cs_n;
            p_addr_q <= mem_addr;
            if (starving)
                sc_q <= (sc_q == {SCW{1'b1}}) ? sc_q : sc_q + 1'b1;
            else
                sc_q <= '0;
        end
    end

    // R4
    starve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        starving |-> (sc_q < SCW'(STARVE_CYC)));

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_zz_n |-> (mem_cs_n && mem_we_n && !host_ready));

    // R3
    pass_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n == !host_sel));

    // R13
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready && mem_zz_n) |-> mem_we_n);

    // R2
    dummy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready && !mem_cs_n) |-> (!mem_oe_n && !mem_lb_n && !mem_ub_n && (mem_addr == '0)));

    // R4
    gap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_ready) && mem_zz_n) |-> mem_cs_n);
endmodule

bind psram_refresh_guard psram_refresh_guard_chk #(
    .AW         (AW),
    .STARVE_CYC (STARVE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_ready (host_ready),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_zz_n   (mem_zz_n),
    .mem_addr   (mem_addr)
);

// File: tb/psram_refresh_guard_tb_top.sv
// Bench for the refresh guard: directed corner cases plus seeded random traffic.
module psram_refresh_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 8;
    localparam int PWR   = 40;
    localparam int WAKE  = 30;
    localparam int HOLD  = 50;
    localparam int RD    = 3;
    localparam int GAP   = 4;
    localparam int S     = 8;
    localparam int NDUM  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_sel = 1'b0, h_wr = 1'b0, h_sleep = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [1:0] h_be = 2'b00;
    logic h_ready, m_cs_n, m_we_n, m_oe_n, m_lb_n, m_ub_n, m_zz_n;
    logic [AW-1:0] m_addr;

    logic hs_sleep = 1'b1;
    logic hh_ready, hh_cs_n, hh_we_n, hh_oe_n, hh_lb_n, hh_ub_n, hh_zz_n;
    logic [AW-1:0] hh_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    psram_refresh_guard #(
        .AW(AW), .PWRUP_CYC(PWR), .WAKE_CYC(WAKE), .HOLD_CYC(HOLD), .WAKE_HOLD(0),
        .RD_CYC(RD), .GAP_CYC(GAP), .STARVE_CYC(S), .DUMMY_RD(NDUM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(h_sel), .host_wr(h_wr), .host_addr(h_addr),
        .host_be_n(h_be), .host_sleep(h_sleep), .host_ready(h_ready),
        .mem_cs_n(m_cs_n), .mem_we_n(m_we_n), .mem_oe_n(m_oe_n), .mem_lb_n(m_lb_n),
        .mem_ub_n(m_ub_n), .mem_zz_n(m_zz_n), .mem_addr(m_addr)
    );

    psram_refresh_guard #(
        .AW(AW), .PWRUP_CYC(PWR), .WAKE_CYC(WAKE), .HOLD_CYC(HOLD), .WAKE_HOLD(1),
        .RD_CYC(RD), .GAP_CYC(GAP), .STARVE_CYC(S), .DUMMY_RD(NDUM)
    ) dut_h (
        .clk(clk), .rst_n(rst_n), .host_sel(1'b0), .host_wr(1'b0), .host_addr('0),
        .host_be_n(2'b11), .host_sleep(hs_sleep), .host_ready(hh_ready),
        .mem_cs_n(hh_cs_n), .mem_we_n(hh_we_n), .mem_oe_n(hh_oe_n), .mem_lb_n(hh_lb_n),
        .mem_ub_n(hh_ub_n), .mem_zz_n(hh_zz_n), .mem_addr(hh_addr)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Expected pin values for a pass-through cycle.
    function automatic int exp_cs_n(logic sel);
        return sel ? 0 : 1;
    endfunction
    function automatic int exp_oe_n(logic sel, logic wr);
        return (sel && !wr) ? 0 : 1;
    endfunction
    function automatic int exp_we_n(logic sel, logic wr);
        return (sel && wr) ? 0 : 1;
    endfunction

    task automatic adv();
        @(posedge clk);
        #1;
    endtask

    task automatic obs();
        @(negedge clk);
    endtask

    task automatic drive(logic sel, logic wr, logic [AW-1:0] a);
        h_sel = sel; h_wr = wr; h_addr = a;
    endtask

    // Starting at the first low cycle, checks the dummy-read sequence.
    task automatic dummy_check(string req);
        for (int r = 0; r < NDUM; r++) begin
            int len = 0;
            while (m_cs_n == 1'b0 && len < 1000) begin
                if (len == 0) begin
                    check_eq(req, "dummy oe_n", m_oe_n, 0);
                    check_eq(req, "dummy we_n", m_we_n, 1);
                    check_eq(req, "dummy addr", m_addr, 0);
                    check_eq(req, "dummy lanes", {m_ub_n, m_lb_n}, 0);
                    check_eq(req, "dummy ready", h_ready, 0);
                end
                len++;
                obs();
            end
            check_eq(req, "dummy read length", len, RD);
            check_eq(req, "separator ready", h_ready, 0);
            obs();
        end
        check_eq(req, "ready after dummy reads", h_ready, 1);
    endtask

    // Counts ready-high then ready-low cycles of a held or walking access.
    task automatic measure_stall(string req, bit walk, output int hi, output int lo);
        hi = 0; lo = 0;
        obs();
        while (h_ready && hi < 1000) begin
            hi++;
            adv();
            if (walk) h_addr = h_addr + 1'b1;
            obs();
        end
        while (!h_ready && lo < 1000) begin
            if (lo == 0) check_eq(req, "gap cs_n", m_cs_n, 1);
            lo++;
            obs();
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin : main
        int n, hi, lo;
        int seed_v;
        logic prev_csn;
        logic [AW-1:0] prev_addr, held_a;
        int bs, glen;
        bit in_gap, last_rdy, fresh;
        seed_v = $urandom(32'd715);

        // R1 reset state
        repeat (3) @(posedge clk);
        obs();
        check_eq("R1", "reset cs_n", m_cs_n, 1);
        check_eq("R1", "reset ready", h_ready, 0);
        check_eq("R1", "reset zz_n", m_zz_n, 1);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1 power-up wait length, R12 sleep ignored on the second instance
        obs();
        n = 0;
        while (m_cs_n && n < 1000) begin
            if (hh_zz_n != 1'b1) check_eq("R12", "zz_n during start-up", hh_zz_n, 1);
            if (h_ready) check_eq("R1", "ready during wait", h_ready, 0);
            n++;
            obs();
        end
        check_eq("R1", "start-up wait cycles", n, PWR);
        check_eq("R12", "zz_n at first dummy read", hh_zz_n, 1);
        dummy_check("R2");
        check_eq("R12", "held-sleep instance reaches ready", hh_ready, 1);
        obs();
        check_eq("R12", "sleep taken after ready", hh_zz_n, 0);

        // R3 pass-through of a read and a write with byte lanes
        adv(); drive(1, 0, 8'h21); h_be = 2'b10; obs();
        check_eq("R3", "read cs_n", m_cs_n, exp_cs_n(1));
        check_eq("R3", "read oe_n", m_oe_n, exp_oe_n(1, 0));
        check_eq("R3", "read addr", m_addr, 8'h21);
        check_eq("R3", "lower lane", m_lb_n, 0);
        check_eq("R3", "upper lane", m_ub_n, 1);
        adv(); drive(1, 1, 8'h22); h_be = 2'b01; obs();
        check_eq("R3", "write we_n", m_we_n, exp_we_n(1, 1));
        check_eq("R3", "write oe_n", m_oe_n, exp_oe_n(1, 1));
        check_eq("R3", "write upper lane", m_ub_n, 0);
        adv(); drive(0, 0, 8'h00); h_be = 2'b00; obs();
        check_eq("R3", "idle cs_n", m_cs_n, 1);
        check_eq("R3", "idle lanes", {m_ub_n, m_lb_n}, 3);

        // R4 held same-address read, R11 resumes unchanged
        adv(); drive(1, 0, 8'h55);
        measure_stall("R4", 0, hi, lo);
        check_eq("R4", "held read accepted cycles", hi, S + 1);
        check_eq("R4", "gap cycles", lo, GAP);
        check_eq("R11", "resumed addr", m_addr, 8'h55);
        check_eq("R11", "resumed oe_n", m_oe_n, 0);
        check_eq("R11", "resumed cs_n", m_cs_n, 0);
        adv(); drive(0, 0, 0); obs();

        // R5 write burst with walking address
        adv(); drive(1, 1, 8'h10);
        measure_stall("R5", 1, hi, lo);
        check_eq("R5", "walking writes accepted", hi, S);
        check_eq("R5", "gap cycles", lo, GAP);
        held_a = h_addr;
        check_eq("R11", "resumed write addr", m_addr, held_a);
        check_eq("R11", "resumed we_n", m_we_n, 0);
        adv(); drive(0, 0, 0); obs();

        // R6 address-changing reads never stall
        n = 0;
        for (int i = 0; i < 3 * S; i++) begin
            adv(); drive(1, 0, 8'(i * 3 + 1)); obs();
            if (!h_ready) n++;
        end
        check_eq("R6", "stall cycles in read walk", n, 0);
        adv(); drive(0, 0, 0); obs();

        // R7 idle cycle restarts the interval
        n = 0;
        for (int i = 0; i < S - 1; i++) begin
            adv(); drive(1, 1, 8'h33); obs();
            if (!h_ready) n++;
        end
        adv(); drive(0, 0, 8'h33); obs();
        if (!h_ready) n++;
        check_eq("R7", "stalls before idle", n, 0);
        adv(); drive(1, 1, 8'h33);
        measure_stall("R7", 0, hi, lo);
        check_eq("R7", "writes accepted after idle", hi, S);
        adv(); drive(0, 0, 0); obs();

        // Random traffic, R3 R4 R5 monitored from the pins
        prev_csn = 1'b1; prev_addr = '0; bs = 0; glen = 0; in_gap = 0; last_rdy = 1;
        for (int i = 0; i < 3000; i++) begin
            adv();
            if (last_rdy) begin
                int r;
                r = $urandom % 10;
                if (r == 0)      drive(0, 0, h_addr);
                else if (r < 3)  drive(1, 0, 8'($urandom));
                else if (r < 5)  drive(1, 0, h_addr);
                else if (r < 8)  drive(1, 1, h_addr);
                else             drive(1, 1, 8'($urandom));
                h_be = 2'($urandom);
            end
            obs();
            if (h_ready) begin
                if (in_gap) begin
                    check_eq("R4", "random gap length", glen, GAP);
                    in_gap = 0; glen = 0;
                end
                check_eq("R3", "random cs_n", m_cs_n, exp_cs_n(h_sel));
                if (!m_cs_n) begin
                    fresh = !m_oe_n && (prev_csn || (m_addr != prev_addr));
                    bs = fresh ? 0 : bs + 1;
                    if (bs > S) check_eq("R5", "starving run bound", bs, S);
                end else begin
                    bs = 0;
                end
            end else begin
                if (!in_gap) check_eq("R4", "random gap cs_n", m_cs_n, 1);
                in_gap = 1; glen++; bs = 0;
            end
            prev_csn = m_cs_n; prev_addr = m_addr; last_rdy = h_ready;
        end
        if (in_gap) begin
            while (!h_ready && glen < 1000) begin glen++; obs(); end
        end

        // R8 deep power-down, R9 wake with dummy reads
        adv(); drive(0, 0, 0); h_sleep = 1'b1; obs();
        check_eq("R8", "ready in request cycle", h_ready, 1);
        adv(); obs();
        check_eq("R8", "zz_n low", m_zz_n, 0);
        check_eq("R8", "ready low", h_ready, 0);
        for (int i = 0; i < 5; i++) begin
            adv(); drive(1, 1, 8'(i)); obs();
            check_eq("R8", "host ignored cs_n", m_cs_n, 1);
            check_eq("R8", "host ignored we_n", m_we_n, 1);
        end
        adv(); drive(0, 0, 0); h_sleep = 1'b0; obs();
        check_eq("R8", "zz_n in release cycle", m_zz_n, 0);
        obs();
        check_eq("R9", "zz_n after release", m_zz_n, 1);
        n = 0;
        while (m_cs_n && n < 1000) begin n++; obs(); end
        check_eq("R9", "wake wait cycles", n, WAKE);
        dummy_check("R9");

        // R10 hold-only wake on the second instance
        adv(); hs_sleep = 1'b0; obs();
        check_eq("R10", "zz_n in release cycle", hh_zz_n, 0);
        obs();
        n = 0;
        while (!hh_ready && n < 1000) begin
            if (!hh_cs_n) check_eq("R10", "cs_n during hold", hh_cs_n, 1);
            n++;
            obs();
        end
        check_eq("R10", "hold cycles", n, HOLD);

        summary();
        $finish;
    end
endmodule